// File: doc/BRIEF.md
# Modulo Timer with Overflow Flag

This block is a 16-bit up-counter driven by a selectable prescaled tick. When the count has reached a programmable modulo value, the next tick returns it to zero, and the same edge raises an overflow flag. Software controls and watches the timer through a small synchronous byte register port. The port has an address, a read strobe, a write strobe and write data, and it returns read data in the same cycle. One interrupt request output follows the overflow flag when interrupts are enabled.

The timer leaves reset halted. Software programs the modulo value, picks a prescaler division or the external clock, and then clears the halt bit. The overflow flag can only be cleared by a two-step handshake. Software first reads the control byte while the flag is set, then writes zero to the flag bit. An overflow that arrives between those two steps voids the handshake, so an event is never lost. Reading the counter high byte captures the low byte, so that a 16-bit value read as two bytes is consistent.

Top module: `modtmr_top`

## Requirements
- R1: After reset, the control byte reads 0x20 (halted, all else 0), the counter reads 0x0000, the modulo value reads 0xFFFF and irq_o is 0.
- R2: Addresses are 0 = control, 1 = counter high, 2 = counter low, 3 = modulo high, 4 = modulo low. In the control byte, bit 7 is the overflow flag, bit 6 the interrupt enable, bit 5 the halt bit, bit 4 the counter-clear command and bits 2:0 the prescaler select. Bit 4 and bit 3 always read 0, and the other writable bits read back as written.
- R3: With select s in 0..6, modulo M, a clear command and a run start on the same write edge, the counter reads floor(n / 2^s) mod (M+1) after n further clock edges.
- R4: The overflow flag is set on the edge where the counter wraps from M to 0x0000, and not before.
- R5: A write of 0 to bit 7 clears the flag only if the control byte was read with the flag set since the last control write. A write of 1 to bit 7 never sets the flag.
- R6: A wrap that occurs after the arming read and before the clearing write leaves the flag set.
- R7: While the halt bit is 1, the counter holds its value. Writes to the counter addresses have no effect.
- R8: Writing 1 to bit 4 clears the counter to 0x0000 and restarts the prescaler divider on that write edge.
- R9: Select 7 counts rising edges of ext_clk_i after a two-stage synchronizer.
- R10: irq_o is 1 exactly when the overflow flag and the interrupt enable are both 1.
- R11: A read of counter high stores the counter low byte of that moment. The next counter low read returns the stored byte. A counter low read with no high read before it returns the live byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_i | input | 3 | Register address |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid in the strobe cycle |
| ext_clk_i | input | 1 | External count clock (asynchronous) |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
The count function is driven with random pairs of prescaler select and modulo value, at run lengths both short of and past several wraps. This separates divider errors from wrap-point errors, and when the modulo exceeds 255 it also exposes faults in the high byte. Directed runs place a wrap after the arming read of the flag handshake, compare a write with no arming read against one that has it, and read the counter while it crosses a byte boundary, which shows whether the low byte was captured. An external-clock run and a clear issued while the divider is mid-count show whether synchronizer edges are counted and whether the divider restarts.

// File: rtl/modtmr_pkg.sv
`timescale 1ns/1ps
package modtmr_pkg;
    localparam int BUS_W = 8;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_CNTH = 3'd1;
    localparam logic [ADDR_W-1:0] A_CNTL = 3'd2;
    localparam logic [ADDR_W-1:0] A_MODH = 3'd3;
    localparam logic [ADDR_W-1:0] A_MODL = 3'd4;

    localparam int B_FLAG = 7;
    localparam int B_IE   = 6;
    localparam int B_HALT = 5;
    localparam int B_CLR  = 4;
endpackage

// File: rtl/modtmr_presc.sv
`timescale 1ns/1ps
module modtmr_presc #(
    parameter int PS_W   = 3,
    parameter int SYNC_N = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run_i,
    input  logic            clr_i,
    input  logic [PS_W-1:0] sel_i,
    input  logic            ext_i,
    output logic            tick_o
);
    localparam int DIV_W = (1 << PS_W) - 2;
    localparam logic [PS_W-1:0] EXT_SEL = {PS_W{1'b1}};

    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic [SYNC_N-1:0] sync;
        logic              ext_prev;
    } presc_t;

    presc_t st_q, st_d;
    logic [DIV_W-1:0] mask;
    logic int_tick, ext_rise;

    always_comb begin
        mask     = DIV_W'((DIV_W+1)'(1) << sel_i) - DIV_W'(1);
        int_tick = run_i && ((st_q.div & mask) == mask);
        ext_rise = st_q.sync[SYNC_N-1] && !st_q.ext_prev;
        tick_o   = (sel_i == EXT_SEL) ? (run_i && ext_rise) : int_tick;

        st_d          = st_q;
        st_d.sync     = {st_q.sync[SYNC_N-2:0], ext_i};
        st_d.ext_prev = st_q.sync[SYNC_N-1];
        if (clr_i) begin
            st_d.div = '0;
        end else if (run_i) begin
            st_d.div = st_q.div + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R7: a halted timer produces no ticks
    p_no_tick_halted_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |-> !tick_o);
    // R3: select 0 ticks on every running clock
    p_div_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && sel_i == '0) |-> tick_o);
endmodule

// File: rtl/modtmr_count.sv
`timescale 1ns/1ps
module modtmr_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             clr_i,
    input  logic [CNT_W-1:0] mod_i,
    output logic [CNT_W-1:0] count_o,
    output logic             wrap_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_t;

    cnt_t st_q, st_d;

    always_comb begin
        wrap_o = tick_i && !clr_i && (st_q.cnt == mod_i);
        st_d   = st_q;
        if (clr_i) begin
            st_d.cnt = '0;
        end else if (wrap_o) begin
            st_d.cnt = '0;
        end else if (tick_i) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
        count_o = st_q.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R3: wrap returns the counter to zero
    p_wrap_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (count_o == '0));
    // R3: an ordinary tick advances by one
    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !clr_i && !wrap_o) |=> (count_o == $past(count_o) + CNT_W'(1)));
    // R8: clear command zeroes the counter
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (count_o == '0));
    // R7: no tick, no change
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !clr_i) |=> $stable(count_o));
endmodule

// File: rtl/modtmr_regs.sv
`timescale 1ns/1ps
module modtmr_regs
    import modtmr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PS_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [BUS_W-1:0]  wdata_i,
    output logic [BUS_W-1:0]  rdata_o,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              wrap_i,
    output logic              run_o,
    output logic              clr_o,
    output logic [PS_W-1:0]   sel_o,
    output logic [CNT_W-1:0]  mod_o,
    output logic              irq_o
);
    typedef struct packed {
        logic             flag;
        logic             ie;
        logic             halt;
        logic [PS_W-1:0]  ps;
        logic             arm;
        logic [CNT_W-1:0] modv;
        logic [BUS_W-1:0] lat;
        logic             lat_vld;
    } regs_t;

    regs_t st_q, st_d;
    logic ctrl_rd, ctrl_wr;
    logic [BUS_W-1:0] rmux;
    wire unused_wbit = wdata_i[3];

    always_comb begin
        ctrl_rd = rd_i && (addr_i == A_CTRL);
        ctrl_wr = wr_i && (addr_i == A_CTRL);
        clr_o   = ctrl_wr && wdata_i[B_CLR];

        st_d = st_q;
        if (ctrl_rd && st_q.flag) begin
            st_d.arm = 1'b1;
        end
        if (ctrl_wr) begin
            st_d.ie   = wdata_i[B_IE];
            st_d.halt = wdata_i[B_HALT];
            st_d.ps   = wdata_i[PS_W-1:0];
            st_d.arm  = 1'b0;
            if (st_q.arm && !wdata_i[B_FLAG]) begin
                st_d.flag = 1'b0;
            end
        end
        if (wrap_i) begin
            st_d.flag = 1'b1;
            st_d.arm  = 1'b0;
        end
        if (wr_i && addr_i == A_MODH) begin
            st_d.modv[CNT_W-1:8] = wdata_i[CNT_W-9:0];
        end
        if (wr_i && addr_i == A_MODL) begin
            st_d.modv[7:0] = wdata_i;
        end
        if (rd_i && addr_i == A_CNTH) begin
            st_d.lat     = count_i[7:0];
            st_d.lat_vld = 1'b1;
        end
        if (rd_i && addr_i == A_CNTL) begin
            st_d.lat_vld = 1'b0;
        end

        case (addr_i)
            A_CTRL:  rmux = {st_q.flag, st_q.ie, st_q.halt, 2'b00, st_q.ps};
            A_CNTH:  rmux = BUS_W'(count_i >> 8);
            A_CNTL:  rmux = st_q.lat_vld ? st_q.lat : count_i[7:0];
            A_MODH:  rmux = BUS_W'(st_q.modv >> 8);
            A_MODL:  rmux = st_q.modv[7:0];
            default: rmux = '0;
        endcase
        rdata_o = rd_i ? rmux : '0;

        run_o = !st_q.halt;
        sel_o = st_q.ps;
        mod_o = st_q.modv;
        irq_o = st_q.flag && st_q.ie;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.halt <= 1'b1;
            st_q.modv <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    // R4: a wrap always leaves the flag set
    p_flag_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_i |=> st_q.flag);
    // R4: the flag rises only because of a wrap
    p_flag_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.flag) |-> $past(wrap_i));
    // R5: without an arming read the flag cannot drop
    p_keep_unarmed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && !st_q.arm) |=> st_q.flag);
    // R6: a wrap voids any pending handshake
    p_wrap_disarms_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_i |=> !st_q.arm);
endmodule

// File: rtl/modtmr_top.sv
`timescale 1ns/1ps
module modtmr_top
    import modtmr_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int PS_W   = 3,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [BUS_W-1:0]  wdata_i,
    output logic [BUS_W-1:0]  rdata_o,
    input  logic              ext_clk_i,
    output logic              irq_o
);
    logic [CNT_W-1:0] count, modv;
    logic [PS_W-1:0]  sel;
    logic wrap, run, clr, tick;

    modtmr_regs #(.CNT_W(CNT_W), .PS_W(PS_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .rd_i(rd_i), .wr_i(wr_i),
        .wdata_i(wdata_i), .rdata_o(rdata_o), .count_i(count), .wrap_i(wrap),
        .run_o(run), .clr_o(clr), .sel_o(sel), .mod_o(modv), .irq_o(irq_o)
    );

    modtmr_presc #(.PS_W(PS_W), .SYNC_N(SYNC_N)) u_presc (
        .clk(clk), .rst_n(rst_n), .run_i(run), .clr_i(clr), .sel_i(sel),
        .ext_i(ext_clk_i), .tick_o(tick)
    );

    modtmr_count #(.CNT_W(CNT_W)) u_count (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .clr_i(clr), .mod_i(modv),
        .count_o(count), .wrap_o(wrap)
    );

    // R10: request only while the flag is visible
    p_irq_needs_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> ($past(wrap) || $past(wr_i)));
endmodule

// File: tb/tb_modtmr_top.sv
`timescale 1ns/1ps
module tb_modtmr_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] addr = '0;
    logic rd = 1'b0, wr = 1'b0, ext = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic irq;
    int n_tests = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    modtmr_top dut (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .rd_i(rd), .wr_i(wr),
        .wdata_i(wdata), .rdata_o(rdata), .ext_clk_i(ext), .irq_o(irq)
    );

    function automatic logic [31:0] exp_count(int n, int s, int m);
        return 32'((n >> s) % (m + 1));
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wreg(input logic [2:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr = 1'b1;
        @(posedge clk); @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rreg(input logic [2:0] a, output logic [7:0] d);
        addr = a; rd = 1'b1;
        #1 d = rdata;
        @(posedge clk); @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic rcnt(output logic [15:0] v);
        logic [7:0] h, l;
        rreg(3'd1, h);
        rreg(3'd2, l);
        v = {h, l};
    endtask

    task automatic setmod(input int m);
        wreg(3'd3, 8'(m >> 8));
        wreg(3'd4, 8'(m));
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] b;
        logic [15:0] v, v2;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rreg(3'd0, b); chk("R1 ctrl", b, 8'h20);
        chk("R1 irq", irq, 1'b0);
        rcnt(v); chk("R1 count", v, 16'h0000);
        rreg(3'd3, b); chk("R1 mod hi", b, 8'hFF);
        rreg(3'd4, b); chk("R1 mod lo", b, 8'hFF);

        // R2 readback, bit 3 and bit 4 read zero
        wreg(3'd0, 8'h2D); rreg(3'd0, b); chk("R2 readback", b, 8'h25);
        wreg(3'd0, 8'h35); rreg(3'd0, b); chk("R2 clear bit reads 0", b, 8'h25);

        // R7 counter writes ignored
        wreg(3'd2, 8'h55); wreg(3'd1, 8'hAA);
        rcnt(v); chk("R7 counter write ignored", v, 16'h0000);

        // R3 / R4 directed wrap with M=5
        wreg(3'd0, 8'h20); setmod(5);
        wreg(3'd0, 8'h10);
        repeat (4) @(negedge clk);
        rreg(3'd0, b); chk("R4 no flag before wrap", b, 8'h00);
        repeat (3) @(negedge clk);
        rcnt(v); chk("R3 wrap count", v, exp_count(8, 0, 5));
        rreg(3'd0, b); chk("R4 flag after wrap", b, 8'h80);

        // R5 handshake with counter halted, M=0 keeps wrapping until halt
        setmod(0);
        wreg(3'd0, 8'h20);
        wreg(3'd0, 8'h20); rreg(3'd0, b); chk("R5 unarmed write keeps flag", b, 8'hA0);
        wreg(3'd0, 8'h20); rreg(3'd0, b); chk("R5 armed write clears flag", b, 8'h20);
        wreg(3'd0, 8'hA0); rreg(3'd0, b); chk("R5 writing 1 does not set", b, 8'h20);

        // R6 wrap between arming read and clearing write, M=3
        setmod(3);
        wreg(3'd0, 8'h10);
        repeat (5) @(negedge clk);
        rreg(3'd0, b); chk("R6 flag seen", b, 8'h80);
        repeat (3) @(negedge clk);
        wreg(3'd0, 8'h20); rreg(3'd0, b); chk("R6 flag survives", b, 8'hA0);

        // R10 interrupt request
        chk("R10 irq off without enable", irq, 1'b0);
        wreg(3'd0, 8'hE0); chk("R10 irq on", irq, 1'b1);
        wreg(3'd0, 8'hA0); chk("R10 irq off when disabled", irq, 1'b0);
        wreg(3'd0, 8'hE0); rreg(3'd0, b); wreg(3'd0, 8'h60);
        chk("R10 irq off after clear", irq, 1'b0);

        // R7 halted counter holds
        rcnt(v); repeat (20) @(negedge clk); rcnt(v2);
        chk("R7 halted hold", v2, v);

        // R8 clear command and divider restart
        wreg(3'd0, 8'h30); rcnt(v); chk("R8 clear", v, 16'h0000);
        setmod(16'hFFFF);
        wreg(3'd0, 8'h06);
        repeat (37) @(negedge clk);
        wreg(3'd0, 8'h16);
        repeat (63) @(negedge clk);
        rcnt(v); chk("R8 divider restart before step", v, 16'h0000);
        rcnt(v); chk("R8 divider restart step", v, 16'h0001);

        // R11 coherent read across a byte boundary
        wreg(3'd0, 8'h10);
        repeat (300) @(negedge clk);
        rcnt(v); chk("R11 coherent pair", v, 16'd300);
        rreg(3'd2, b); chk("R11 live low byte", b, 8'(302));

        // R9 external clock
        wreg(3'd0, 8'h17);
        for (int i = 0; i < 5; i++) begin
            ext = 1'b1; repeat (4) @(negedge clk);
            ext = 1'b0; repeat (4) @(negedge clk);
        end
        repeat (6) @(negedge clk);
        rcnt(v); chk("R9 external edges", v, 16'd5);

        // R3 random select / modulo / run length
        for (int t = 0; t < 40; t++) begin
            int s, m, n;
            s = int'($urandom % 7);
            m = int'($urandom % 1024);
            n = int'($urandom % 700);
            wreg(3'd0, 8'h20);
            setmod(m);
            wreg(3'd0, 8'(8'h10 | s));
            repeat (n) @(negedge clk);
            rcnt(v);
            chk($sformatf("R3 random s=%0d m=%0d n=%0d", s, m, n), v, exp_count(n, s, m));
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule